// File: doc/BRIEF.md
# Direction-Finding Antenna Switch Sequencer

This block paces the constant-tone tail that follows a received packet when the angle of arrival is being measured. After a start pulse it runs a silent guard interval, then a fixed reference period on the first antenna, then a switching period. In the switching period, switch slots and sample slots alternate, each half the programmed switch spacing long. Every switch slot selects the next entry of a programmable list of one-hot antenna words. The block emits a single-cycle IQ sample strobe at the programmed spacing. Each strobe carries a running sample number and the index of the list entry that was driving the antenna lines when the sample was taken.

The switching-period sampling grid is deliberately offset from the switching grid. No sample is taken in the first switch slot. The first switching-period sample falls on the first cycle of the first sample slot. When the sample spacing is shorter than a slot, samples also land inside switch slots. Those samples are tagged with the entry that the switch slot has just applied. One clock cycle is one timing tick (62.5 ns at a 16 MHz tick), and every spacing input is given in ticks. A done pulse marks the end of the extension, after which the antenna lines fall to zero.

Top module: `df_switch_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `ant_sel` is all-zero and `smp_vld` and `done` are low.
- R2: A start pulse seen by a clock edge while idle begins a guard interval of GUARD_TICKS cycles, counted from the cycle after that edge. During the guard interval no sample strobe is issued and `ant_sel` carries list entry 0.
- R3: The reference period follows the guard and lasts REF_TICKS cycles on entry 0. A strobe tagged 0 is issued on its first cycle and then every `ref_spacing` cycles while inside the period.
- R4: The switching period is divided into slots of `sw_spacing`/2 cycles, starting with a switch slot and then alternating with sample slots. A new list entry takes effect on the first cycle of every switch slot and holds unchanged through the following sample slot.
- R5: No strobe is issued during the first switch slot. The first switching-period strobe comes on the first cycle of the first sample slot, which is `sw_spacing`/2 cycles into the switching period.
- R6: After that first strobe, switching-period strobes repeat every `sw_smp_spacing` cycles until the extension ends. Each is tagged with the entry selected at the start of the slot it falls in, including strobes that fall in switch slots.
- R7: Switch slots walk entries 1, 2, ..., `pat_len`-1, then wrap back to entry 1. Entry 0 is used only for the guard and reference periods.
- R8: `smp_idx` counts strobes from 0 at the first reference sample and continues without restart into the switching period.
- R9: `done` is high for exactly one cycle, `ext_units`×UNIT_TICKS cycles after the start edge (offset 0 being the first cycle after the edge). `ant_sel` is all-zero from that cycle on.
- R10: A start pulse arriving while a sequence is running has no effect on the antenna lines, the strobes, their indices or the done timing.
- R11: `ant_sel` equals bits [k·N_ANT +: N_ANT] of `pat_list`, where k is the current entry. With one-hot words 1, 2, 4 and 8, exactly one of four antenna lines is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per timing tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (ignored while running) |
| ext_units | input | EXT_W | Extension length in units of UNIT_TICKS (8 µs) |
| ref_spacing | input | SP_W | Sample spacing in the reference period, ticks |
| sw_spacing | input | SP_W | Switch spacing in ticks; each slot is half of it |
| sw_smp_spacing | input | SP_W | Sample spacing in the switching period, ticks |
| pat_len | input | LEN_W | Number of valid list entries, including entry 0 |
| pat_list | input | N_PAT·N_ANT | Antenna words; entry k in bits [k·N_ANT +: N_ANT] |
| ant_sel | output | N_ANT | Antenna select lines |
| smp_vld | output | 1 | Single-cycle IQ sample strobe |
| smp_idx | output | SMP_W | Running sample number of the strobe |
| smp_tag | output | IDX_W | List entry active for the strobe |
| done | output | 1 | One-cycle pulse at the end of the extension |

## Verification
The hardest situation to reach is a strobe that falls on the very first cycle of a switch slot while the entry list is wrapping. On that cycle, the tag and the antenna word must already be the new entry, and a one-cycle slip anywhere shows up only there. The stimulus uses a short list of three entries together with a sample spacing equal to the slot length, so that strobes land exactly on every slot boundary and the wrap occurs several times within one run. A second start pulse is injected in the middle of that run to show that it leaves the sequence untouched.

// File: rtl/df_seq_pkg.sv
package df_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_GUARD  = 2'd1,
        PH_REF    = 2'd2,
        PH_SWITCH = 2'd3
    } phase_e;

endpackage

// File: rtl/df_sample_pacer.sv
// Modulo tick counter: strobes on the first enabled cycle after a clear
// and then every 'period' enabled cycles.
module df_sample_pacer #(
    parameter int SP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic [SP_W-1:0] period,
    output logic            hit
);

    logic [SP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = (cnt_q >= period - SP_W'(1)) ? '0 : cnt_q + SP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = en && (cnt_q == '0);

    AST_PACE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && period != '0 && cnt_q < period) |=> (cnt_q < period || $changed(period))); // R6

endmodule

// File: rtl/df_pattern_walker.sv
// Holds the active list entry and selects its antenna word.
module df_pattern_walker #(
    parameter int N_ANT = 4,
    parameter int N_PAT = 8,
    localparam int IDX_W = (N_PAT > 1) ? $clog2(N_PAT) : 1,
    localparam int LEN_W = $clog2(N_PAT + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load0,
    input  logic                   adv,
    input  logic [LEN_W-1:0]       pat_len,
    input  logic [N_PAT*N_ANT-1:0] pat_list,
    output logic [IDX_W-1:0]       idx,
    output logic [N_ANT-1:0]       pat
);

    logic [IDX_W-1:0] idx_d, idx_q;
    logic [LEN_W:0]   nxt;

    always_comb begin
        idx_d = idx_q;
        nxt   = (LEN_W+1)'(idx_q) + (LEN_W+1)'(1);
        if (load0) begin
            idx_d = '0;
        end else if (adv) begin
            idx_d = (nxt >= (LEN_W+1)'(pat_len)) ? IDX_W'(1) : IDX_W'(nxt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;
    assign pat = pat_list[idx_q*N_ANT +: N_ANT];

    AST_ADV_SKIPS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load0) |=> (idx_q != '0)); // R7

endmodule

// File: rtl/df_switch_seq.sv
module df_switch_seq
    import df_seq_pkg::*;
#(
    parameter int N_ANT       = 4,
    parameter int N_PAT       = 8,
    parameter int GUARD_TICKS = 64,
    parameter int REF_TICKS   = 128,
    parameter int UNIT_TICKS  = 128,
    parameter int EXT_W       = 6,
    parameter int SP_W        = 8,
    localparam int T_W   = $clog2(UNIT_TICKS * ((1 << EXT_W) - 1) + 1),
    localparam int SMP_W = T_W,
    localparam int IDX_W = (N_PAT > 1) ? $clog2(N_PAT) : 1,
    localparam int LEN_W = $clog2(N_PAT + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [EXT_W-1:0]       ext_units,
    input  logic [SP_W-1:0]        ref_spacing,
    input  logic [SP_W-1:0]        sw_spacing,
    input  logic [SP_W-1:0]        sw_smp_spacing,
    input  logic [LEN_W-1:0]       pat_len,
    input  logic [N_PAT*N_ANT-1:0] pat_list,
    output logic [N_ANT-1:0]       ant_sel,
    output logic                   smp_vld,
    output logic [SMP_W-1:0]       smp_idx,
    output logic [IDX_W-1:0]       smp_tag,
    output logic                   done
);

    typedef struct packed {
        phase_e            phase;
        logic [T_W-1:0]    tcnt;
        logic [SP_W-1:0]   slot_cnt;
        logic              smp_slot;
        logic              smp_on;
        logic [SMP_W-1:0]  smp_idx;
        logic              done;
    } seq_t;

    seq_t r_d, r_q;

    logic              load0, adv, pclr, pen, hit;
    logic [SP_W-1:0]   period;
    logic [SP_W-1:0]   slot_len;
    logic              slot_end;
    logic [T_W-1:0]    sw_len;
    logic [IDX_W-1:0]  cur_idx;
    logic [N_ANT-1:0]  cur_pat;

    assign slot_len = sw_spacing >> 1;
    assign slot_end = (r_q.slot_cnt == slot_len - SP_W'(1));
    assign sw_len   = T_W'(ext_units) * T_W'(UNIT_TICKS) - T_W'(GUARD_TICKS + REF_TICKS);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        load0    = 1'b0;
        adv      = 1'b0;
        pclr     = 1'b0;
        pen      = 1'b0;
        period   = ref_spacing;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (start) begin
                    r_d.phase   = PH_GUARD;
                    r_d.tcnt    = '0;
                    r_d.smp_idx = '0;
                    load0       = 1'b1;
                end
            end
            PH_GUARD: begin
                r_d.tcnt = r_q.tcnt + T_W'(1);
                if (r_q.tcnt == T_W'(GUARD_TICKS - 1)) begin
                    r_d.phase = PH_REF;
                    r_d.tcnt  = '0;
                    pclr      = 1'b1;
                end
            end
            PH_REF: begin
                pen      = 1'b1;
                r_d.tcnt = r_q.tcnt + T_W'(1);
                if (hit) r_d.smp_idx = r_q.smp_idx + SMP_W'(1);
                if (r_q.tcnt == T_W'(REF_TICKS - 1)) begin
                    r_d.phase    = PH_SWITCH;
                    r_d.tcnt     = '0;
                    r_d.slot_cnt = '0;
                    r_d.smp_slot = 1'b0;
                    r_d.smp_on   = 1'b0;
                    adv          = 1'b1;
                end
            end
            PH_SWITCH: begin
                period       = sw_smp_spacing;
                pen          = r_q.smp_on;
                r_d.tcnt     = r_q.tcnt + T_W'(1);
                r_d.slot_cnt = slot_end ? '0 : r_q.slot_cnt + SP_W'(1);
                if (hit) r_d.smp_idx = r_q.smp_idx + SMP_W'(1);
                if (slot_end) begin
                    r_d.smp_slot = ~r_q.smp_slot;
                    adv          = r_q.smp_slot;
                    if (!r_q.smp_on) begin
                        r_d.smp_on = 1'b1;
                        pclr       = 1'b1;
                    end
                end
                if (r_q.tcnt == sw_len - T_W'(1)) begin
                    r_d.phase = PH_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.phase <= PH_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    df_sample_pacer #(.SP_W(SP_W)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pclr),
        .en     (pen),
        .period (period),
        .hit    (hit)
    );

    df_pattern_walker #(.N_ANT(N_ANT), .N_PAT(N_PAT)) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .load0    (load0),
        .adv      (adv),
        .pat_len  (pat_len),
        .pat_list (pat_list),
        .idx      (cur_idx),
        .pat      (cur_pat)
    );

    assign ant_sel = (r_q.phase != PH_IDLE) ? cur_pat : '0;
    assign smp_vld = hit;
    assign smp_idx = r_q.smp_idx;
    assign smp_tag = cur_idx;
    assign done    = r_q.done;

    AST_GUARD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_GUARD) |-> !smp_vld); // R2

    AST_FIRST_SLOT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_SWITCH && !r_q.smp_on) |-> !smp_vld); // R5

    AST_HOLD_IN_SAMPLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_SWITCH && r_q.smp_slot) |-> $stable(smp_tag)); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ant_sel == '0 && !smp_vld)); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.phase == PH_REF || r_q.phase == PH_SWITCH) && start) |=> (r_q.phase != PH_GUARD)); // R10

endmodule

// File: tb/sim_df_switch_seq.sv
`timescale 1ns/1ps
module sim_df_switch_seq;

    localparam int G    = 64;
    localparam int REFT = 128;
    localparam int U    = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  ext_units = 6'd3;
    logic [7:0]  ref_spacing = 8'd4;
    logic [7:0]  sw_spacing = 8'd32;
    logic [7:0]  sw_smp_spacing = 8'd4;
    logic [3:0]  pat_len = 4'd5;
    logic [31:0] pat_list = '0;
    logic [3:0]  ant_sel;
    logic        smp_vld;
    logic [12:0] smp_idx;
    logic [2:0]  smp_tag;
    logic        done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        int idx;
        int tag;
        int off;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    df_switch_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ext_units(ext_units),
        .ref_spacing(ref_spacing), .sw_spacing(sw_spacing),
        .sw_smp_spacing(sw_smp_spacing), .pat_len(pat_len), .pat_list(pat_list),
        .ant_sel(ant_sel), .smp_vld(smp_vld), .smp_idx(smp_idx),
        .smp_tag(smp_tag), .done(done)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int word_of(int e);
        return int'(pat_list[e*4 +: 4]);
    endfunction

    // Entry active at tick t of the switching period (R4, R7)
    function automatic int entry_at(int t, int swsp, int plen);
        return ((t / swsp) % (plen - 1)) + 1;
    endfunction

    task automatic run_case(int ext, int rsp, int swsp, int ssp, int plen,
                            logic [31:0] plist, bit mid_start, string name);
        int swlen;
        int span;
        ext_units      = 6'(ext);
        ref_spacing    = 8'(rsp);
        sw_spacing     = 8'(swsp);
        sw_smp_spacing = 8'(ssp);
        pat_len        = 4'(plen);
        pat_list       = plist;
        swlen = ext * U - G - REFT;
        span  = ext * U;
        $display("case %s", name);
        fork
            begin : driver
                int n = 0;
                for (int k = 0; k * rsp < REFT; k++) begin
                    sb.push_back('{n, 0, G + k * rsp});
                    n++;
                end
                for (int t = swsp / 2; t < swlen; t += ssp) begin
                    sb.push_back('{n, entry_at(t, swsp, plen), G + REFT + t});
                    n++;
                end
                @(negedge clk) start = 1'b1;
                @(negedge clk) start = 1'b0;
                if (mid_start) begin
                    repeat (150) @(negedge clk);
                    start = 1'b1;               // R10: restart attempt mid-run
                    @(negedge clk) start = 1'b0;
                end
            end
            begin : monitor
                int ant_err = 0;
                int ant_first_k = -1;
                int ant_act = 0;
                int ant_exp = 0;
                int done_err = 0;
                int done_at = -1;
                bit first_sw = 1'b1;
                @(negedge clk);
                @(negedge clk);
                for (int k = 0; k <= span + 2; k++) begin
                    int ea;
                    if (k < G + REFT)  ea = word_of(0);
                    else if (k < span) ea = word_of(entry_at(k - G - REFT, swsp, plen));
                    else               ea = 0;
                    if (int'(ant_sel) != ea && ant_err == 0) begin
                        ant_first_k = k;
                        ant_act = int'(ant_sel);
                        ant_exp = ea;
                    end
                    if (int'(ant_sel) != ea) ant_err++;
                    if (done) begin
                        if (done_at < 0) done_at = k;
                        else done_err++;
                    end
                    if (smp_vld) begin
                        if (sb.size() == 0) begin
                            chk("R6", "unexpected strobe offset", k, -1);
                        end else begin
                            exp_t e = sb.pop_front();
                            string rq;
                            if (e.tag == 0)     rq = "R3";
                            else if (first_sw)  rq = "R5";
                            else                rq = "R6";
                            if (e.tag != 0) first_sw = 1'b0;
                            chk(rq, "strobe offset", k, e.off);
                            chk("R8", "sample index", int'(smp_idx), e.idx);
                            chk(rq, "sample tag", int'(smp_tag), e.tag);
                            chk("R11", "antenna word at strobe", int'(ant_sel), word_of(e.tag));
                        end
                    end
                    @(negedge clk);
                end
                chk("R5", "strobes never issued", sb.size(), 0);
                sb.delete();
                if (ant_err != 0)
                    $display("  antenna mismatch first at offset %0d: %0d vs %0d",
                             ant_first_k, ant_act, ant_exp);
                chk("R4", "antenna trace mismatches (R2 R7 R11)", ant_err, 0);
                chk("R9", "done offset", done_at, span);
                chk("R9", "extra done cycles", done_err, 0);
                chk(mid_start ? "R10" : "R1", "idle lines after run",
                    int'(ant_sel) + int'(smp_vld) + int'(done), 0);
            end
        join
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "ant_sel in reset", int'(ant_sel), 0);
        chk("R1", "smp_vld in reset", int'(smp_vld), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "ant_sel idle", int'(ant_sel), 0);
        chk("R1", "done idle", int'(done), 0);

        // Four one-hot antennas: entry0=1, entries 1..4 = 1,2,4,8; 1 us slots, 250 ns sampling
        run_case(3, 4, 32, 4, 5, {12'h0, 4'h8, 4'h4, 4'h2, 4'h1, 4'h1}, 1'b0, "oversampled four antennas");
        repeat (4) @(negedge clk);
        // Three entries, sampling on every slot boundary, restart attempt mid-run
        run_case(4, 8, 16, 8, 3, {20'h0, 4'h2, 4'h4, 4'h8}, 1'b1, "wrap with slot-edge sampling");
        repeat (4) @(negedge clk);
        // Short extension, coarse spacings
        run_case(2, 16, 64, 16, 4, {16'h0, 4'h8, 4'h2, 4'h4, 4'h1}, 1'b0, "short extension");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule